// File: doc/BRIEF.md
# Dual-Edge I/Q Transmit Word Capture

This block sits at the digital edge of a two-channel transmit converter. A single 10-bit data bus carries the in-phase (I) and quadrature (Q) sample words, interleaved in time: the I word is presented for the falling clock edge and the Q word for the following rising edge. The block takes both words off the shared bus and presents them as two parallel registered codes. Both codes change together, on the rising edge that takes the Q word, so the converter behind it always sees a matched I/Q pair.

A transmit-enable input from mode control gates the path. While transmit is off, the bus is treated as if every line were pulled high and its contents never reach the outputs. Both codes are held at the midscale idle code, which is the converter's zero level. An output-valid strobe marks each rising edge at which a fresh pair was loaded.

Top module: `iq_ddr_capture`

## Requirements
- R1: The I word is taken from the bus on the falling clock edge. It is the word that appears on `i_code` after the next rising edge.
- R2: The Q word is taken from the bus on the rising clock edge. At that same edge `i_code` and `q_code` are loaded together with the pair made of that Q word and the I word from the falling edge just before it.
- R3: `out_valid` is 1 for the cycle that follows each rising edge at which a pair is loaded. A pair is loaded when `tx_en` was 1 at both the falling edge and the rising edge. In every other cycle `out_valid` is 0.
- R4: When `tx_en` is 0 at a rising edge, `i_code` and `q_code` become the midscale code 10'h200 at that edge and `out_valid` becomes 0.
- R5: While `tx_en` is 0, the value on `tx_data` has no effect on `i_code`, `q_code` or `out_valid`. The bus is internally replaced by all ones.
- R6: If `tx_en` is 0 at a falling edge and 1 at the next rising edge, no pair is loaded at that rising edge. `i_code` and `q_code` keep their values and `out_valid` is 0.
- R7: Reset is synchronous and active low. A rising edge with `rst_n` at 0 sets `i_code` and `q_code` to 10'h200 and `out_valid` to 0. This holds whatever `tx_en` and `tx_data` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. Both edges are used. |
| rst_n | input | 1 | Synchronous active-low reset. |
| tx_en | input | 1 | Transmit enable from mode control. |
| tx_data | input | 10 | Shared bus: the I word for the falling edge, the Q word for the rising edge. |
| i_code | output | 10 | Registered I channel code. |
| q_code | output | 10 | Registered Q channel code. |
| out_valid | output | 1 | High for one cycle after each loaded pair. |

## Verification
The bench drives distinct I and Q words in every cycle. A design that took I on the rising edge would show the Q word on both outputs. A design that paired I with the wrong rising edge would show the outputs one word out of step. Disabled cycles carry non-idle bus patterns: a design that let the bus leak through would show those patterns instead of midscale, and one that failed to drop the strobe would keep `out_valid` high. Two directed cases target the edges of the enable and reset timing. One raises `tx_en` between a falling and a rising edge, where a design that loaded a stale or all-ones I word would show a change or a strobe. The other asserts reset during an enabled pair, where the outputs must go to midscale and not load the pair.

// File: rtl/iq_cap_pkg.sv
// Package: shared constants and helpers for the dual-edge I/Q capture block.
// Assumes code words are unsigned offset-binary, with the idle level at midscale.
package iq_cap_pkg;

    // Default code width of each channel.
    localparam int unsigned DEF_CODE_W = 10;

    // Number of channels carried on the shared bus.
    localparam int unsigned NUM_CHAN = 2;

    // Channel index used for the per-channel output registers.
    typedef enum logic [0:0] {
        CHAN_I = 1'b0,
        CHAN_Q = 1'b1
    } chan_e;

    // Midscale code for a given width: only the top bit set.
    function automatic logic [31:0] midscale(input int unsigned width);
        logic [31:0] v;
        v = 32'd0;
        v[width-1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/iq_bus_gate.sv
// Module: iq_bus_gate
// Replaces the shared bus with all ones while transmit is off, as if every line were pulled high.
// Assumes the enable is stable around the edges that sample its output.
module iq_bus_gate #(
    parameter int unsigned W = iq_cap_pkg::DEF_CODE_W
) (
    input  logic         en,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_eff
);

    // One gating cell per bus line.
    for (genvar b = 0; b < W; b++) begin : g_line
        assign bus_eff[b] = en ? bus_in[b] : 1'b1;
    end

endmodule

// File: rtl/iq_fall_capture.sv
// Module: iq_fall_capture
// Takes the I word off the gated bus on the falling clock edge. It also records
// whether transmit was on at that edge, so that the rising-edge stage knows the word is fresh.
// Assumes the reset level is sampled at the falling edge as well, synchronously.
module iq_fall_capture #(
    parameter int unsigned W = iq_cap_pkg::DEF_CODE_W,
    parameter logic [W-1:0] RST_VAL = W'(iq_cap_pkg::midscale(W))
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_q,
    output logic         fresh_q
);

    // Falling-edge register for the I word.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            word_q <= RST_VAL;
        end else begin
            word_q <= din;
        end
    end

    // Falling-edge flag: the captured word belongs to an enabled cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b0;
        end else begin
            fresh_q <= en;
        end
    end

endmodule

// File: rtl/iq_pair_output.sv
// Module: iq_pair_output
// On the rising edge, loads the held I word and the Q word from the bus into the
// output registers together, or forces both to the idle code when transmit is off.
// Assumes i_fresh comes from a falling-edge register in the same clock domain.
module iq_pair_output #(
    parameter int unsigned W = iq_cap_pkg::DEF_CODE_W,
    parameter logic [W-1:0] IDLE = W'(iq_cap_pkg::midscale(W))
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         i_fresh,
    input  logic [W-1:0] i_word,
    input  logic [W-1:0] q_word,
    output logic [W-1:0] i_out,
    output logic [W-1:0] q_out,
    output logic         valid
);

    localparam int unsigned NCH = iq_cap_pkg::NUM_CHAN;

    logic [W-1:0] src [NCH];
    logic [W-1:0] dst [NCH];
    logic         load;

    assign src[iq_cap_pkg::CHAN_I] = i_word;
    assign src[iq_cap_pkg::CHAN_Q] = q_word;
    assign load = en && i_fresh;

    // One output register per channel, all loaded on the same edge.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Rising-edge code register: reset, idle, load or hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst[c] <= IDLE;
            end else if (!en) begin
                dst[c] <= IDLE;
            end else if (load) begin
                dst[c] <= src[c];
            end
        end
    end

    // Rising-edge strobe: high for the cycle after a pair is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= load;
        end
    end

    assign i_out = dst[iq_cap_pkg::CHAN_I];
    assign q_out = dst[iq_cap_pkg::CHAN_Q];

endmodule

// File: rtl/iq_ddr_capture.sv
// Module: iq_ddr_capture (top)
// Splits an I/Q bus that changes on both clock edges into two parallel registered codes
// that update together, plus a strobe for each new pair.
// Assumes the bus is stable around both clock edges and that tx_en changes away from the edges.
module iq_ddr_capture #(
    parameter int unsigned W = iq_cap_pkg::DEF_CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] i_code,
    output logic [W-1:0] q_code,
    output logic         out_valid
);

    localparam logic [W-1:0] MID = W'(iq_cap_pkg::midscale(W));

    logic [W-1:0] bus_eff;
    logic [W-1:0] i_hold;
    logic         i_fresh;

    iq_bus_gate #(.W(W)) gate_i (
        .en      (tx_en),
        .bus_in  (tx_data),
        .bus_eff (bus_eff)
    );

    iq_fall_capture #(.W(W), .RST_VAL(MID)) fall_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .din     (bus_eff),
        .word_q  (i_hold),
        .fresh_q (i_fresh)
    );

    iq_pair_output #(.W(W), .IDLE(MID)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .i_fresh (i_fresh),
        .i_word  (i_hold),
        .q_word  (bus_eff),
        .i_out   (i_code),
        .q_out   (q_code),
        .valid   (out_valid)
    );

endmodule

// File: rtl/iq_ddr_capture_chk.sv
// Module: iq_ddr_capture_chk
// Assertion checker for iq_ddr_capture, attached by bind. It watches ports only.
// Assumes the bench holds reset low over the first rising edge.
module iq_ddr_capture_chk #(
    parameter int unsigned W = iq_cap_pkg::DEF_CODE_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_en,
    input logic [W-1:0] tx_data,
    input logic [W-1:0] i_code,
    input logic [W-1:0] q_code,
    input logic         out_valid
);

    localparam logic [W-1:0] MID = W'(iq_cap_pkg::midscale(W));

    // R7: a reset edge leaves midscale codes and no strobe.
    p_reset_mid_r7: assert property (@(posedge clk)
        !rst_n |=> (i_code == MID) && (q_code == MID) && !out_valid);

    // R4, R5: a disabled rising edge forces idle codes, whatever is on the bus.
    p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (i_code == MID) && (q_code == MID) && !out_valid);

    // R2: a loaded Q code is the bus value at the loading rising edge.
    p_q_from_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (q_code == $past(tx_data)));

    // R3: the strobe only follows an enabled rising edge.
    p_valid_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tx_en));

    // R6: with no strobe and transmit on over two edges, codes either hold or are idle.
    p_hold_no_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(tx_en) && $past(rst_n)) |->
            ($stable(i_code) && $stable(q_code)));

endmodule

bind iq_ddr_capture iq_ddr_capture_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_data   (tx_data),
    .i_code    (i_code),
    .q_code    (q_code),
    .out_valid (out_valid)
);

// File: tb/iq_ddr_capture_tb_top.sv
// Bench for iq_ddr_capture: a vector table walked pair by pair, then directed cases.
module iq_ddr_capture_tb_top;

    localparam int unsigned W = 10;
    localparam logic [W-1:0] MID = 10'h200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_en = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic [W-1:0] i_code;
    logic [W-1:0] q_code;
    logic         out_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    iq_ddr_capture #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .tx_data   (tx_data),
        .i_code    (i_code),
        .q_code    (q_code),
        .out_valid (out_valid)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Vector: {en, i_word, q_word, exp_i, exp_q, exp_valid}
    localparam int NV = 10;
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 10'h155, 10'h2AA, 10'h155, 10'h2AA, 1'b1},
        {1'b1, 10'h3FF, 10'h000, 10'h3FF, 10'h000, 1'b1},
        {1'b1, 10'h000, 10'h3FF, 10'h000, 10'h3FF, 1'b1},
        {1'b0, 10'h123, 10'h321, 10'h200, 10'h200, 1'b0},
        {1'b0, 10'h3FF, 10'h3FF, 10'h200, 10'h200, 1'b0},
        {1'b1, 10'h001, 10'h200, 10'h001, 10'h200, 1'b1},
        {1'b1, 10'h200, 10'h001, 10'h200, 10'h001, 1'b1},
        {1'b0, 10'h0AB, 10'h0CD, 10'h200, 10'h200, 1'b0},
        {1'b1, 10'h2F0, 10'h10F, 10'h2F0, 10'h10F, 1'b1},
        {1'b1, 10'h0F0, 10'h30F, 10'h0F0, 10'h30F, 1'b1}
    };

    task automatic check(input string req, input logic [W-1:0] ei,
                         input logic [W-1:0] eq, input logic ev);
        checks++;
        if (i_code !== ei || q_code !== eq || out_valid !== ev) begin
            errors++;
            $display("FAIL %s: got i=%h q=%h v=%b expected i=%h q=%h v=%b",
                     req, i_code, q_code, out_valid, ei, eq, ev);
        end
    endtask

    // Called just after a rising edge; drives one I/Q pair and returns just after the next rising edge.
    task automatic drive_pair(input logic en, input logic [W-1:0] iw, input logic [W-1:0] qw);
        tx_en = en;
        tx_data = iw;
        @(negedge clk);
        #1;
        tx_data = qw;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        tx_en = 1'b1;
        tx_data = 10'h155;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset state", MID, MID, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5: walk the table.
        for (int k = 0; k < NV; k++) begin
            drive_pair(VEC[k][41], VEC[k][40:31], VEC[k][30:21]);
            check("R1 R2 R3 R4 R5 vector", VEC[k][20:11], VEC[k][10:1], VEC[k][0]);
        end

        // R6: enable rises between a falling and a rising edge.
        drive_pair(1'b0, 10'h3C3, 10'h111);
        check("R4 before R6", MID, MID, 1'b0);
        tx_en = 1'b0;
        tx_data = 10'h077;
        @(negedge clk);
        #1;
        tx_en = 1'b1;
        tx_data = 10'h1E1;
        @(posedge clk);
        #1;
        check("R6 late enable", MID, MID, 1'b0);
        drive_pair(1'b1, 10'h0AA, 10'h355);
        check("R6 next pair loads", 10'h0AA, 10'h355, 1'b1);

        // R7: reset during an enabled pair.
        rst_n = 1'b0;
        drive_pair(1'b1, 10'h012, 10'h345);
        check("R7 reset mid-run", MID, MID, 1'b0);
        rst_n = 1'b1;
        drive_pair(1'b1, 10'h2BC, 10'h0DE);
        check("R7 after reset", 10'h2BC, 10'h0DE, 1'b1);

        // R3: strobe drops after a disabled cycle.
        drive_pair(1'b0, 10'h2BC, 10'h0DE);
        check("R3 strobe drops", MID, MID, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule